// File: doc/BRIEF.md
# Pipelined Integer-to-Float Converter

This block turns a 32-bit signed two's-complement integer into an IEEE 754 single-precision word. A caller presents an operand and a 2-bit rounding mode with a valid strobe on any cycle. The block accepts one operand per cycle with no stall, and the packed float leaves a fixed number of cycles later together with an inexact flag.

Five register stages do the work in order. The first sorts out the two inputs that skip the datapath, which are zero and the most negative integer. In that same stage it forms the magnitude and, in parallel, predicts the leading-zero count. The second stage fixes the prediction, derives the biased exponent and left-aligns the magnitude into a 24-bit significand plus guard, round and sticky bits. The third stage rounds, and a carry out of the significand raises the exponent. The fourth stage packs the fields, and the last stage registers the result at the outputs.

Top module: `int2flt_conv`

## Requirements
- R1: `outValid` is low out of reset. Each cycle with `inValid` high yields exactly one cycle with `outValid` high, 5 clock cycles later, in issue order, including back-to-back issues and gaps.
- R2: An operand of 0 gives `outFloat` = 0x00000000 with `outInexact` low, in every rounding mode.
- R3: The operand 0x80000000 gives `outFloat` = 0xCF000000 with `outInexact` low, in every rounding mode.
- R4: Bit 31 of `outFloat` equals bit 31 of the operand for every nonzero operand. A negative operand is converted through its two's-complement magnitude.
- R5: Bits 30:23 of `outFloat` hold 127 plus the index of the leading one of the magnitude, or one more after a rounding carry. Bits 22:0 hold the rounded significand with its leading one dropped.
- R6: Any operand with magnitude below 2^24 converts exactly, whatever the rounding mode, and `outInexact` stays low.
- R7: `roundMode` = 00 rounds to nearest. On an exact half-way case it rounds up only when the kept significand is odd.
- R8: `roundMode` = 01 truncates the magnitude, which rounds toward zero.
- R9: `roundMode` = 10 rounds toward minus infinity. An inexact negative value grows in magnitude, and an inexact positive value is truncated.
- R10: `roundMode` = 11 rounds toward plus infinity. An inexact positive value grows in magnitude, and an inexact negative value is truncated.
- R11: When rounding up turns an all-ones significand into a power of two, the exponent rises by one and the fraction becomes zero. For example, 0x7FFFFFFF in mode 00 gives 0x4F000000.
- R12: `outInexact` is high exactly when the bits discarded by the conversion are nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand and mode are valid this cycle |
| inInt | input | 32 | Signed two's-complement operand |
| roundMode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward minus infinity, 11 toward plus infinity |
| outValid | output | 1 | Result valid this cycle |
| outFloat | output | 32 | Single-precision result: sign, 8-bit exponent, 23-bit fraction |
| outInexact | output | 1 | Result differs from the operand's exact value |

## Verification
Several internal faults have a distinct signature at the ports. If the one-bit fix-up of the predicted leading-zero count goes wrong, it appears only for negative operands whose magnitude is a power of two. There the exponent is off by one and the fraction is shifted, and this shows five cycles after the offending issue. A wrong sticky or guard bit turns up only for magnitudes of 2^24 and above. It shows as a one-ulp error or a wrong inexact flag in one rounding mode, so every mode must see operands just above, exactly at and just below a half-way point. A broken valid chain shows up as a missing, duplicated or misaligned result. The bench therefore time-stamps every issue and matches every `outValid` pulse against it.

// File: rtl/int2flt_pkg.sv
package int2flt_pkg;

  localparam int INT_W      = 32;
  localparam int EXP_W      = 8;
  localparam int FRAC_W     = 23;
  localparam int SIG_W      = FRAC_W + 1;
  localparam int EXT_W      = 3;
  localparam int NORM_W     = SIG_W + EXT_W;
  localparam int SUM_W      = SIG_W + 1;
  localparam int LZ_W       = $clog2(INT_W) + 1;
  localparam int EXP_BIAS   = 127;
  localparam int EXP_TOP    = EXP_BIAS + INT_W - 1;
  localparam int PIPE_DEPTH = 5;
  localparam int FLT_W      = 1 + EXP_W + FRAC_W;

  localparam logic [INT_W-1:0] MIN_INT   = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [FLT_W-1:0] FLT_ZERO  = '0;
  localparam logic [FLT_W-1:0] FLT_MINNEG = {1'b1, EXP_W'(EXP_TOP), {FRAC_W{1'b0}}};

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_DOWN = 2'b10,
    RM_UP   = 2'b11
  } roundModeT;

  typedef enum logic [1:0] {
    K_NORM   = 2'b00,
    K_ZERO   = 2'b01,
    K_MINNEG = 2'b10
  } opKindT;

  // One load enable per register stage, driven by the valid chain.
  typedef struct packed {
    logic ldOut;
    logic ldD;
    logic ldC;
    logic ldB;
    logic ldA;
  } stageStrobesT;

  function automatic logic [LZ_W-1:0] countLead(input logic [INT_W-1:0] v);
    logic [LZ_W-1:0] n;
    logic found;
    n = LZ_W'(INT_W);
    found = 1'b0;
    for (int i = INT_W - 1; i >= 0; i--) begin
      if (!found && v[i]) begin
        n = LZ_W'(INT_W - 1 - i);
        found = 1'b1;
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/int2flt_ctrl.sv
module int2flt_ctrl
  import int2flt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output stageStrobesT strobes,
  output logic         outValid
);

  logic [PIPE_DEPTH-1:0] validPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validPipe <= '0;
    else       validPipe <= {validPipe[PIPE_DEPTH-2:0], inValid};
  end

  always_comb begin
    strobes.ldA   = inValid;
    strobes.ldB   = validPipe[0];
    strobes.ldC   = validPipe[1];
    strobes.ldD   = validPipe[2];
    strobes.ldOut = validPipe[3];
  end

  assign outValid = validPipe[PIPE_DEPTH-1];

endmodule

// File: rtl/int2flt_dp.sv
module int2flt_dp
  import int2flt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  stageStrobesT     strobes,
  input  logic [INT_W-1:0] inInt,
  input  logic [1:0]       roundMode,
  output logic [FLT_W-1:0] outFloat,
  output logic             outInexact
);

  // ---------------- stage A: operand capture ----------------
  logic [INT_W-1:0] aOpnd;
  roundModeT        aMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aOpnd <= '0;
      aMode <= RM_NEAR;
    end else if (strobes.ldA) begin
      aOpnd <= inInt;
      aMode <= roundModeT'(roundMode);
    end
  end

  // Special detect, negation and leading-zero prediction side by side.
  logic             aSign;
  opKindT           aKind;
  logic [INT_W-1:0] aOnes;
  logic [INT_W-1:0] aMag;
  logic [LZ_W-1:0]  aPredLz;

  always_comb begin
    aSign   = aOpnd[INT_W-1];
    aKind   = (aOpnd == '0) ? K_ZERO : ((aOpnd == MIN_INT) ? K_MINNEG : K_NORM);
    aOnes   = aOpnd ^ {INT_W{aSign}};
    aMag    = aOnes + INT_W'(aSign);
    aPredLz = countLead(aOnes);
  end

  // ---------------- stage B: normalize ----------------
  logic             bSign;
  opKindT           bKind;
  roundModeT        bMode;
  logic [INT_W-1:0] bMag;
  logic [LZ_W-1:0]  bPredLz;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bSign   <= 1'b0;
      bKind   <= K_ZERO;
      bMode   <= RM_NEAR;
      bMag    <= '0;
      bPredLz <= '0;
    end else if (strobes.ldB) begin
      bSign   <= aSign;
      bKind   <= aKind;
      bMode   <= aMode;
      bMag    <= aMag;
      bPredLz <= aPredLz;
    end
  end

  logic [LZ_W-1:0]   bIdx;
  logic              bProbe;
  logic [LZ_W-1:0]   bLz;
  logic [INT_W-1:0]  bShift;
  logic [EXP_W-1:0]  bExp;
  logic [NORM_W-1:0] bNorm;

  always_comb begin
    // The ones'-complement count can be one too high when the magnitude is a
    // power of two; the bit just above the predicted leading one tells.
    bIdx   = LZ_W'(INT_W) - bPredLz;
    bProbe = bMag[bIdx[LZ_W-2:0]];
    bLz    = bPredLz - LZ_W'(bProbe);
    bShift = bMag << bLz[LZ_W-2:0];
    bExp   = EXP_W'(EXP_TOP) - EXP_W'(bLz);
    bNorm  = {bShift[INT_W-1 -: SIG_W+2], |bShift[INT_W-SIG_W-3:0]};
  end

  // ---------------- stage C: round ----------------
  logic              cSign;
  opKindT            cKind;
  roundModeT         cMode;
  logic [EXP_W-1:0]  cExp;
  logic [NORM_W-1:0] cNorm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cSign <= 1'b0;
      cKind <= K_ZERO;
      cMode <= RM_NEAR;
      cExp  <= '0;
      cNorm <= '0;
    end else if (strobes.ldC) begin
      cSign <= bSign;
      cKind <= bKind;
      cMode <= bMode;
      cExp  <= bExp;
      cNorm <= bNorm;
    end
  end

  logic [SIG_W-1:0]  cSig;
  logic              cGuard, cRnd, cStky, cAnyExt, cInc, cCarry;
  logic [SUM_W-1:0]  cSum;
  logic [FRAC_W-1:0] cFrac;
  logic [EXP_W-1:0]  cExpAdj;

  always_comb begin
    cSig    = cNorm[NORM_W-1:EXT_W];
    cGuard  = cNorm[2];
    cRnd    = cNorm[1];
    cStky   = cNorm[0];
    cAnyExt = cGuard | cRnd | cStky;
    case (cMode)
      RM_NEAR: cInc = cGuard & (cRnd | cStky | cSig[0]);
      RM_ZERO: cInc = 1'b0;
      RM_DOWN: cInc = cSign & cAnyExt;
      RM_UP:   cInc = ~cSign & cAnyExt;
      default: cInc = 1'b0;
    endcase
    cSum    = {1'b0, cSig} + SUM_W'(cInc);
    cCarry  = cSum[SUM_W-1];
    cFrac   = cCarry ? cSum[SIG_W-1:1] : cSum[FRAC_W-1:0];
    cExpAdj = cExp + EXP_W'(cCarry);
  end

  // ---------------- stage D: pack ----------------
  logic              dSign;
  opKindT            dKind;
  logic [EXP_W-1:0]  dExp;
  logic [FRAC_W-1:0] dFrac;
  logic              dInexact;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dSign    <= 1'b0;
      dKind    <= K_ZERO;
      dExp     <= '0;
      dFrac    <= '0;
      dInexact <= 1'b0;
    end else if (strobes.ldD) begin
      dSign    <= cSign;
      dKind    <= cKind;
      dExp     <= cExpAdj;
      dFrac    <= cFrac;
      dInexact <= cAnyExt & (cKind == K_NORM);
    end
  end

  logic [FLT_W-1:0] dWord;

  always_comb begin
    case (dKind)
      K_ZERO:   dWord = FLT_ZERO;
      K_MINNEG: dWord = FLT_MINNEG;
      default:  dWord = {dSign, dExp, dFrac};
    endcase
  end

  // ---------------- output register ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outFloat   <= '0;
      outInexact <= 1'b0;
    end else if (strobes.ldOut) begin
      outFloat   <= dWord;
      outInexact <= dInexact;
    end
  end

endmodule

// File: rtl/int2flt_conv.sv
module int2flt_conv
  import int2flt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] inInt,
  input  logic [1:0]  roundMode,
  output logic        outValid,
  output logic [31:0] outFloat,
  output logic        outInexact
);

  stageStrobesT strobes;

  int2flt_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  int2flt_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .inInt      (inInt),
    .roundMode  (roundMode),
    .outFloat   (outFloat),
    .outInexact (outInexact)
  );

endmodule

// File: rtl/int2flt_checks.sv
module int2flt_checks
  import int2flt_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [31:0] inInt,
  input logic        outValid,
  input logic [31:0] outFloat,
  input logic        outInexact
);

  // Counts clocks since reset so that $past never reaches into reset.
  logic [2:0] sinceRst;
  logic       warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  assign warm = (sinceRst >= 3'd6);

  logic [7:0] expField;
  assign expField = outFloat[30:23];

  p_valid_delay_r1: assert property (@(posedge clk) disable iff (!rstN)
    warm |-> (outValid == $past(inValid, 5)));

  p_zero_const_r2: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(inValid, 5) && ($past(inInt, 5) == 32'h0))
      |-> (outFloat == 32'h0 && !outInexact));

  p_minneg_const_r3: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(inValid, 5) && ($past(inInt, 5) == 32'h8000_0000))
      |-> (outFloat == 32'hCF00_0000 && !outInexact));

  p_sign_follows_r4: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(inValid, 5) && ($past(inInt, 5) != 32'h0))
      |-> (outFloat[31] == $past(inInt[31], 5)));

  p_exp_window_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((outFloat[30:0] == 31'h0) ||
                  (expField >= 8'(EXP_BIAS) && expField <= 8'(EXP_TOP))));

  p_small_exact_r6: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(inValid, 5) &&
     ($past(inInt, 5) < 32'h0100_0000 || $past(inInt, 5) > 32'hFF00_0000))
      |-> !outInexact);

  p_inexact_large_r12: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outInexact) |-> (expField >= 8'(EXP_BIAS + SIG_W)));

endmodule

bind int2flt_conv int2flt_checks u_checks (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .inInt      (inInt),
  .outValid   (outValid),
  .outFloat   (outFloat),
  .outInexact (outInexact)
);

// File: tb/int2flt_conv_test.sv
module int2flt_conv_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inInt = '0;
  logic [1:0]  roundMode = '0;
  logic        outValid;
  logic [31:0] outFloat;
  logic        outInexact;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  logic [31:0] qX[4096];
  logic [1:0]  qM[4096];
  int          qStamp[4096];
  int          wrPtr = 0;
  int          rdPtr = 0;

  always #10ns clk = ~clk;

  int2flt_conv uut (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inInt      (inInt),
    .roundMode  (roundMode),
    .outValid   (outValid),
    .outFloat   (outFloat),
    .outInexact (outInexact)
  );

  // Independent model: integer remainder compared against the half-way point.
  function automatic void refConv(input logic [31:0] x, input logic [1:0] rm,
                                  output logic [31:0] f, output logic inex,
                                  output logic carry);
    logic [63:0] mag, keep, rem, half;
    logic        sgn, up;
    int          e, sh;
    f = 32'h0; inex = 1'b0; carry = 1'b0;
    if (x == 32'h0) return;
    sgn = x[31];
    mag = sgn ? (64'({1'b0, ~x}) + 64'd1) : 64'(x);
    e = 0;
    for (int i = 0; i < 64; i++) if (mag[i]) e = i;
    if (e <= 23) begin
      keep = mag << (23 - e);
      rem = 64'd0; half = 64'd0;
    end else begin
      sh = e - 23;
      keep = mag >> sh;
      rem = mag & ((64'd1 << sh) - 64'd1);
      half = 64'd1 << (sh - 1);
    end
    case (rm)
      2'b00: up = (rem > half) || (rem == half && rem != 0 && keep[0]);
      2'b01: up = 1'b0;
      2'b10: up = sgn && rem != 0;
      default: up = !sgn && rem != 0;
    endcase
    keep = keep + 64'(up);
    if (keep[24]) begin
      keep = keep >> 1;
      e = e + 1;
      carry = 1'b1;
    end
    inex = (rem != 0);
    f = {sgn, 8'(e + 127), keep[22:0]};
  endfunction

  function automatic string reqOf(input logic [31:0] x, input logic [1:0] rm,
                                  input logic carry);
    if (x == 32'h0) return "R2";
    if (x == 32'h8000_0000) return "R3";
    if (carry) return "R11";
    if (x < 32'h0100_0000 || x > 32'hFF00_0000) return "R6";
    case (rm)
      2'b00: return "R7";
      2'b01: return "R8";
      2'b10: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic checkEq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  task automatic observe();
    logic [31:0] ef, x;
    logic        ei, ec;
    logic [1:0]  m;
    if (outValid) begin
      if (rdPtr == wrPtr) begin
        checkEq("R1", "unexpected outValid", 32'd1, 32'd0);
      end else begin
        x = qX[rdPtr % 4096]; m = qM[rdPtr % 4096];
        checkEq("R1", "latency", 32'(cyc - qStamp[rdPtr % 4096]), 32'd5);
        refConv(x, m, ef, ei, ec);
        checkEq(reqOf(x, m, ec), $sformatf("result x=%08h mode=%0d", x, m), outFloat, ef);
        if (x != 32'h0) checkEq("R4", "sign bit", 32'(outFloat[31]), 32'(x[31]));
        checkEq("R5", "exponent field", 32'(outFloat[30:23]), 32'(ef[30:23]));
        checkEq("R12", "inexact flag", 32'(outInexact), 32'(ei));
        rdPtr++;
      end
    end else if (rdPtr != wrPtr && (cyc - qStamp[rdPtr % 4096]) >= 5) begin
      checkEq("R1", "missing outValid", 32'd0, 32'd1);
      rdPtr++;
    end
  endtask

  task automatic stepCycle(input logic v, input logic [31:0] x, input logic [1:0] m);
    @(negedge clk);
    cyc++;
    observe();
    inValid = v;
    inInt = x;
    roundMode = m;
    if (v) begin
      qX[wrPtr % 4096] = x;
      qM[wrPtr % 4096] = m;
      qStamp[wrPtr % 4096] = cyc;
      wrPtr++;
    end
  endtask

  function automatic logic [31:0] randOperand();
    logic [31:0] r;
    int k;
    r = $urandom;
    case ($urandom % 5)
      0: return r;
      1: return r >> ($urandom % 32);
      2: return -(r >> ($urandom % 32));
      3: begin
        k = 1 + ($urandom % 7);
        return ((r | 32'h0100_0000) & ~((32'd1 << k) - 1)) | (32'd1 << (k - 1));
      end
      default: begin
        k = 1 + ($urandom % 7);
        return -(((r | 32'h0100_0000) & ~((32'd1 << k) - 1)) | (32'd1 << (k - 1)));
      end
    endcase
  endfunction

  localparam logic [31:0] DIRECTED[18] = '{
    32'h0000_0000, 32'h8000_0000, 32'h0000_0001, 32'hFFFF_FFFF,
    32'h7FFF_FFFF, 32'h00FF_FFFF, 32'hFF00_0001, 32'h0100_0001,
    32'h0100_0003, 32'hFEFF_FFFF, 32'hFEFF_FFFD, 32'h01FF_FFFF,
    32'hFE00_0001, 32'h4000_0000, 32'hC000_0000, 32'h0100_0002,
    32'h7FFF_FFC0, 32'h8000_0001
  };

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // reset state (R1)
    checkEq("R1", "reset outValid", 32'(outValid), 32'd0);
    checkEq("R1", "reset outFloat", outFloat, 32'h0);
    checkEq("R12", "reset outInexact", 32'(outInexact), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    stepCycle(1'b0, 32'h0, 2'b00);

    // directed corners, back to back, every rounding mode
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 18; i++)
        stepCycle(1'b1, DIRECTED[i], 2'(m));
    repeat (8) stepCycle(1'b0, 32'h0, 2'b00);

    // constrained random with bubbles
    for (int n = 0; n < 3000; n++)
      stepCycle(($urandom % 4) != 0, randOperand(), 2'($urandom % 4));
    repeat (10) stepCycle(1'b0, 32'h0, 2'b00);

    checkEq("R1", "all results returned", 32'(wrPtr - rdPtr), 32'd0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule